// File: doc/BRIEF.md
# NAND Page-Program Host Sequencer

This block sits on the host side of an 8-bit NAND flash bus and carries out one page-program operation for each request. A requester hands over a 32-bit page/column address on a valid/ready handshake, then streams the page data one byte at a time on a second valid/ready handshake that carries an end-of-stream marker. The sequencer drives the flash bus through the whole operation. It sends the program setup command, the four address bytes, the data bytes and the program confirm command. Each of these bus cycles uses the command-latch and address-latch strobes and a write-enable pulse whose width is set by a parameter.

After the confirm command the sequencer lets the device settle and then waits for the ready/busy line to return high. It then issues the read-status command and reads the status byte with a read-enable pulse. The status byte is used only when its ready bit is set. If the ready bit is clear, the sequencer polls again. When polling ends, it returns a one-cycle completion pulse with a pass/fail result. The data stream is capped at 528 bytes. A stream that runs past the cap is cut off, the operation is still confirmed, and an overflow error is flagged with the result. A watchdog on the busy period ends an operation that never completes and reports a timeout.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, and whenever no operation is in progress, `req_ready` is 1, `nand_cle`/`nand_ale`/`done` are 0 and `nand_we_n`/`nand_re_n` are 1. A request is taken only while `req_ready` is 1. A `req_valid` pulse during an operation changes nothing, and no bus activity occurs between operations.
- R2: Bytes are latched on the rising edge of `nand_we_n`, and they follow a fixed order. First comes command 0x80. Next come four address bytes, least significant byte of `req_addr` first. Then come the data bytes, and last the command 0x10.
- R3: `nand_cle` is 1 only during command cycles and `nand_ale` is 1 only during address cycles. Both are 0 during data cycles, and they are never 1 together.
- R4: Each write cycle holds `nand_we_n` low for exactly STROBE_CLKS clocks and then high for STROBE_CLKS clocks. `nand_cle`, `nand_ale` and `nand_dout` do not change while `nand_we_n` is low. `nand_we_n` and `nand_re_n` are never low together, and a read cycle holds `nand_re_n` low for exactly STROBE_CLKS clocks.
- R5: Accepted data bytes (`wr_valid` and `wr_ready` both 1 at a clock edge) go out on the bus in order. The stream ends at the byte marked with `wr_last`, and any count from 1 to 528 is allowed.
- R6: If 528 bytes are accepted without `wr_last`, the stream ends there and `wr_ready` stays 0 for the rest of the operation. The 0x10 confirm is still sent, and `err_overflow` is 1 with `done`.
- R7: After the confirm, the sequencer waits SETTLE_CLKS clocks. It then starts no further bus cycle until `nand_rb` is 1.
- R8: Once `nand_rb` is 1, command 0x70 is sent and one status byte is read from `nand_din`. If status bit 6 is 0, the command and the read are repeated. If bit 6 is 1, the result is `pass` = 1 when status bit 0 is 0 and `pass` = 0 when it is 1. The other status bits are ignored.
- R9: Counting starts when the settle wait ends. If `nand_rb` is still 0 after TIMEOUT_CLKS clocks, the operation ends with `done` = 1, `err_timeout` = 1 and `pass` = 0, and no 0x70 command is sent.
- R10: `done` is a single-cycle pulse. `pass`, `err_overflow` and `err_timeout` are meaningful only in that cycle and are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | 32 | Page/column address, sent low byte first |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| wr_valid | input | 1 | Data byte offered |
| wr_data | input | 8 | Data byte |
| wr_last | input | 1 | Offered byte is the last of the stream |
| wr_ready | output | 1 | Sequencer takes the offered byte |
| done | output | 1 | Operation finished (one cycle) |
| pass | output | 1 | Program reported success |
| err_overflow | output | 1 | Stream exceeded 528 bytes and was cut |
| err_timeout | output | 1 | Ready/busy stayed low too long |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_doe | output | 1 | Host drives the data bus |
| nand_dout | output | 8 | Byte driven onto the bus |
| nand_din | input | 8 | Byte read from the bus |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The assertions assume two things about the device. It does not pull `nand_rb` low while the sequencer is polling status, and it returns a status byte that stays stable while `nand_re_n` is low. They also assume the requester does not start a new operation until `nand_rb` is high again after a timeout. The bench's device model meets these assumptions by design. It pulls ready/busy low only after it latches a confirm command, and it drives the status byte from a held value. Before each new request the bench waits for ready/busy to return high. The random part varies the data-byte gaps, the stream lengths, the busy durations, the number of not-ready polls and the unused status bits. Directed cases cover a one-byte stream, exactly 528 bytes, an overflowing stream, a failing status, a timeout and a stray request during an operation.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam logic [7:0] OP_PROG_SETUP   = 8'h80;
  localparam logic [7:0] OP_PROG_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS_READ  = 8'h70;
  localparam int ST_FAIL_BIT  = 0;
  localparam int ST_READY_BIT = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_DATA, S_CONFIRM,
    S_SETTLE, S_WAIT_RB, S_STAT_CMD, S_STAT_RD
  } seq_state_e;

  typedef enum logic [1:0] {
    CYC_CMD, CYC_ADDR, CYC_DATA, CYC_READ
  } cyc_kind_e;
endpackage

// File: rtl/nps_strobe.sv
// One bus cycle: strobe low for W clocks, then high for W clocks.
module nps_strobe #(
  parameter int W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rd,
  output logic busy,
  output logic fin,
  output logic sample,
  output logic we_n,
  output logic re_n
);
  localparam int LAST = 2 * W - 1;
  localparam int CW   = $clog2(2 * W + 1);

  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      rd_q <= 1'b0;
      we_n <= 1'b1;
      re_n <= 1'b1;
    end else if (!busy && start) begin
      busy <= 1'b1;
      cnt  <= '0;
      rd_q <= rd;
      we_n <= rd;
      re_n <= !rd;
    end else if (busy) begin
      if (cnt == CW'(LAST)) begin
        busy <= 1'b0;
        we_n <= 1'b1;
        re_n <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          we_n <= 1'b1;
          re_n <= 1'b1;
        end
      end
    end
  end

  assign fin    = busy && (cnt == CW'(LAST));
  assign sample = busy && rd_q && (cnt == CW'(W - 1));
endmodule

// File: rtl/nps_byte_cnt.sv
// Counts accepted data bytes and decides where the stream ends.
module nps_byte_cnt #(
  parameter int MAX_BYTES = 528
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic last_in,
  output logic end_now,
  output logic ovf_now
);
  localparam int CW = $clog2(MAX_BYTES + 1);

  logic [CW-1:0] cnt;
  logic          at_cap;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_cap  = (cnt == CW'(MAX_BYTES - 1));
  assign end_now = last_in || at_cap;
  assign ovf_now = at_cap && !last_in;
endmodule

// File: rtl/nps_tick.sv
// Saturating clock counter with an expiry flag at LIMIT.
module nps_tick #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)            cnt <= '0;
    else if (en && !expired)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int ADDR_BYTES   = 4,
  parameter int MAX_BYTES    = 528,
  parameter int STROBE_CLKS  = 2,
  parameter int SETTLE_CLKS  = 4,
  parameter int TIMEOUT_CLKS = 2000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  output logic                    req_ready,
  input  logic                    wr_valid,
  input  logic [7:0]              wr_data,
  input  logic                    wr_last,
  output logic                    wr_ready,
  output logic                    done,
  output logic                    pass,
  output logic                    err_overflow,
  output logic                    err_timeout,
  output logic                    nand_cle,
  output logic                    nand_ale,
  output logic                    nand_we_n,
  output logic                    nand_re_n,
  output logic                    nand_doe,
  output logic [7:0]              nand_dout,
  input  logic [7:0]              nand_din,
  input  logic                    nand_rb
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  seq_state_e         state;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDX_W-1:0]   idx;
  logic               issued;
  logic               ovf_q;
  logic               end_q;
  logic               st_ready_q;
  logic               st_fail_q;
  logic               stat_unused;

  logic               sb_start, sb_busy, sb_fin, sb_sample;
  logic               cyc_want, can_launch, take_byte;
  cyc_kind_e          cyc_kind;
  logic [7:0]         cyc_byte;
  logic               end_now, ovf_now;
  logic               settle_exp, to_exp;
  logic               to_en;

  assign stat_unused = ^{nand_din[7], nand_din[5:1]};

  // Bus cycle wanted by the current state
  always_comb begin
    cyc_want = 1'b0;
    cyc_kind = CYC_CMD;
    cyc_byte = 8'h00;
    unique case (state)
      S_SETUP:    begin cyc_want = 1'b1; cyc_byte = OP_PROG_SETUP; end
      S_ADDR:     begin cyc_want = 1'b1; cyc_kind = CYC_ADDR;
                        cyc_byte = addr_q[{idx, 3'b000} +: 8]; end
      S_DATA:     begin cyc_want = wr_valid; cyc_kind = CYC_DATA;
                        cyc_byte = wr_data; end
      S_CONFIRM:  begin cyc_want = 1'b1; cyc_byte = OP_PROG_CONFIRM; end
      S_STAT_CMD: begin cyc_want = 1'b1; cyc_byte = OP_STATUS_READ; end
      S_STAT_RD:  begin cyc_want = 1'b1; cyc_kind = CYC_READ; end
      default:    ;
    endcase
  end

  assign can_launch = !sb_busy && !issued;
  assign sb_start   = cyc_want && can_launch;
  assign wr_ready   = (state == S_DATA) && can_launch;
  assign take_byte  = wr_valid && wr_ready;
  assign req_ready  = (state == S_IDLE);
  assign to_en      = (state == S_WAIT_RB) || (state == S_STAT_CMD) ||
                      (state == S_STAT_RD);

  nps_strobe #(.W(STROBE_CLKS)) u_strobe (
    .clk(clk), .rst(rst), .start(sb_start), .rd(cyc_kind == CYC_READ),
    .busy(sb_busy), .fin(sb_fin), .sample(sb_sample),
    .we_n(nand_we_n), .re_n(nand_re_n)
  );

  nps_byte_cnt #(.MAX_BYTES(MAX_BYTES)) u_bytes (
    .clk(clk), .rst(rst), .clr(state == S_IDLE), .inc(take_byte),
    .last_in(wr_last), .end_now(end_now), .ovf_now(ovf_now)
  );

  nps_tick #(.LIMIT(SETTLE_CLKS)) u_settle (
    .clk(clk), .rst(rst), .clr(state != S_SETTLE),
    .en(state == S_SETTLE), .expired(settle_exp)
  );

  nps_tick #(.LIMIT(TIMEOUT_CLKS)) u_timeout (
    .clk(clk), .rst(rst), .clr(state == S_SETTLE),
    .en(to_en), .expired(to_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      addr_q       <= '0;
      idx          <= '0;
      issued       <= 1'b0;
      ovf_q        <= 1'b0;
      end_q        <= 1'b0;
      st_ready_q   <= 1'b0;
      st_fail_q    <= 1'b0;
      done         <= 1'b0;
      pass         <= 1'b0;
      err_overflow <= 1'b0;
      err_timeout  <= 1'b0;
      nand_cle     <= 1'b0;
      nand_ale     <= 1'b0;
      nand_doe     <= 1'b0;
      nand_dout    <= 8'h00;
    end else begin
      done         <= 1'b0;
      pass         <= 1'b0;
      err_overflow <= 1'b0;
      err_timeout  <= 1'b0;

      if (sb_start) begin
        issued    <= 1'b1;
        nand_cle  <= (cyc_kind == CYC_CMD);
        nand_ale  <= (cyc_kind == CYC_ADDR);
        nand_doe  <= (cyc_kind != CYC_READ);
        nand_dout <= (cyc_kind == CYC_READ) ? 8'h00 : cyc_byte;
      end
      if (sb_fin) begin
        issued   <= 1'b0;
        nand_cle <= 1'b0;
        nand_ale <= 1'b0;
        nand_doe <= 1'b0;
      end
      if (sb_sample) begin
        st_ready_q <= nand_din[ST_READY_BIT];
        st_fail_q  <= nand_din[ST_FAIL_BIT];
      end

      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          idx    <= '0;
          ovf_q  <= 1'b0;
          end_q  <= 1'b0;
          state  <= S_SETUP;
        end
        S_SETUP: if (sb_fin) state <= S_ADDR;
        S_ADDR: if (sb_fin) begin
          if (idx == IDX_W'(ADDR_BYTES - 1)) state <= S_DATA;
          else idx <= idx + 1'b1;
        end
        S_DATA: begin
          if (take_byte) begin
            end_q <= end_now;
            ovf_q <= ovf_now;
          end
          if (sb_fin && end_q) state <= S_CONFIRM;
        end
        S_CONFIRM: if (sb_fin) state <= S_SETTLE;
        S_SETTLE:  if (settle_exp) state <= S_WAIT_RB;
        S_WAIT_RB: begin
          if (to_exp) begin
            done         <= 1'b1;
            err_timeout  <= 1'b1;
            err_overflow <= ovf_q;
            state        <= S_IDLE;
          end else if (nand_rb) begin
            state <= S_STAT_CMD;
          end
        end
        S_STAT_CMD: if (sb_fin) state <= S_STAT_RD;
        S_STAT_RD: if (sb_fin) begin
          if (st_ready_q) begin
            done         <= 1'b1;
            pass         <= !st_fail_q;
            err_overflow <= ovf_q;
            state        <= S_IDLE;
          end else begin
            state <= S_WAIT_RB;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nps_chk.sv
module nps_chk #(
  parameter int STROBE_CLKS = 2,
  parameter int MAX_BYTES   = 528
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       done,
  input logic       pass,
  input logic       err_overflow,
  input logic       err_timeout,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_dout
);
  logic [15:0] we_low;
  logic [15:0] accepted;

  always_ff @(posedge clk) begin
    if (rst) we_low <= '0;
    else if (!nand_we_n) we_low <= we_low + 1'b1;
    else we_low <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || (req_valid && req_ready)) accepted <= '0;
    else if (wr_valid && wr_ready) accepted <= accepted + 1'b1;
  end

  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    (nand_we_n && !$past(nand_we_n)) |-> (we_low == 16'(STROBE_CLKS)));

  // R4
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && !$past(nand_we_n)) |->
      ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dout)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> (accepted < 16'(MAX_BYTES)));

  // R1
  handshake_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && wr_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> !(pass || err_overflow || err_timeout));
endmodule

bind nand_prog_seq nps_chk #(
  .STROBE_CLKS(STROBE_CLKS),
  .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .done(done), .pass(pass),
  .err_overflow(err_overflow), .err_timeout(err_timeout),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_dout(nand_dout)
);

// File: tb/sim_nand_prog_seq.sv
`timescale 1ns/1ps
module sim_nand_prog_seq;
  localparam int STROBE  = 2;
  localparam int SETTLE  = 4;
  localparam int TIMEOUT = 300;
  localparam int MAXB    = 528;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_last = 1'b0;
  logic wr_ready;
  logic done, pass, err_overflow, err_timeout;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic [7:0] nand_dout, nand_din;
  logic nand_rb = 1'b1;

  always #10 clk = ~clk;

  nand_prog_seq #(
    .ADDR_BYTES(4), .MAX_BYTES(MAXB), .STROBE_CLKS(STROBE),
    .SETTLE_CLKS(SETTLE), .TIMEOUT_CLKS(TIMEOUT)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .wr_ready(wr_ready), .done(done), .pass(pass),
    .err_overflow(err_overflow), .err_timeout(err_timeout),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_doe(nand_doe), .nand_dout(nand_dout),
    .nand_din(nand_din), .nand_rb(nand_rb)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [9:0] lg [0:1023];
  int lg_n = 0;
  int m_busy = 10, polls_left = 0, reads = 0;
  logic [7:0] m_status = 8'h40;
  int viol_we = 0, viol_re = 0, viol_rb = 0, viol_quiet = 0;
  int wlow = 0, rlow = 0, dly = 0, left = 0;
  bit arm = 0, we_prev = 1, re_prev = 1;

  assign nand_din = !nand_re_n ? ((polls_left > 0) ? (m_status & 8'hBF) : m_status)
                               : 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      if (nand_we_n && !we_prev) begin
        if (lg_n < 1024) lg[lg_n] = {nand_cle, nand_ale, nand_dout};
        lg_n++;
        if (nand_cle && !nand_ale && nand_dout == 8'h10) begin arm = 1; dly = 2; end
        if (wlow != STROBE) viol_we++;
        wlow = 0;
      end
      if (!nand_we_n && we_prev && !nand_rb) viol_rb++;
      if (!nand_we_n) wlow++;
      if (nand_re_n && !re_prev) begin
        reads++;
        if (polls_left > 0) polls_left--;
        if (rlow != STROBE) viol_re++;
        rlow = 0;
      end
      if (!nand_re_n) rlow++;
      if (!done && (pass || err_overflow || err_timeout)) viol_quiet++;
      if (arm) begin
        if (dly == 0) begin nand_rb = 1'b0; arm = 0; left = m_busy; end
        else dly--;
      end else if (!nand_rb) begin
        if (left == 0) nand_rb = 1'b1; else left--;
      end
    end
    we_prev = nand_we_n;
    re_prev = nand_re_n;
  end

  function automatic logic [7:0] dbyte(input int op, input int i);
    return 8'((op * 37) ^ (i * 13) ^ (i >> 3) ^ 8'h5A);
  endfunction

  // ---------------- one operation ----------------
  task automatic run_op(input int opn, input logic [31:0] a, input int n,
                        input int busy, input int polls, input logic [7:0] st,
                        input bit stray);
    int idx = 0, cyc = 0, late_rdy = 0, lg_done = 0, exp_len, nb, bad = 0;
    bit pend = 0, got = 0, r_pass = 0, r_ovf = 0, r_to = 0, exp_to, exp_ovf;
    logic [9:0] e;
    lg_n = 0; reads = 0; m_busy = busy; polls_left = polls; m_status = st;
    exp_to  = (busy > TIMEOUT + 20);
    exp_ovf = (n > MAXB);
    nb      = exp_ovf ? MAXB : n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (pend) begin idx++; pend = 0; end
      if (done) begin got = 1; r_pass = pass; r_ovf = err_overflow; r_to = err_timeout; end
      if (idx >= MAXB && wr_ready) late_rdy++;
      if (stray && cyc == 30) begin req_valid = 1'b1; req_addr = ~a; end
      else req_valid = 1'b0;
      if (idx < n && !got) begin
        wr_valid = ($urandom % 4) != 0;
        wr_data  = dbyte(opn, idx);
        wr_last  = (idx == n - 1);
      end else begin
        wr_valid = 1'b0;
        wr_last  = 1'b0;
      end
      pend = wr_valid && wr_ready;
    end
    wr_valid = 1'b0; req_valid = 1'b0;
    lg_done = lg_n;
    @(negedge clk);
    chk(got, "R10 done seen", got, 1);
    chk(!done, "R10 done single cycle", done, 0);
    chk(r_to == exp_to, "R9 err_timeout", r_to, exp_to);
    chk(r_pass == (!exp_to && !st[0]), "R8 pass result", r_pass, !exp_to && !st[0]);
    chk(r_ovf == exp_ovf, "R6 err_overflow", r_ovf, exp_ovf);
    chk(idx == nb, "R5 bytes accepted", idx, nb);
    if (exp_ovf) chk(late_rdy == 0, "R6 wr_ready after cap", late_rdy, 0);
    exp_len = exp_to ? 6 + nb : 6 + nb + polls + 1;
    chk(lg_done == exp_len, "R2 bus cycle count", lg_done, exp_len);
    for (int i = 0; i < lg_done && i < 1024; i++) begin
      if (i == 0) e = {2'b10, 8'h80};
      else if (i <= 4) e = {2'b01, a[8*(i-1) +: 8]};
      else if (i < 5 + nb) e = {2'b00, dbyte(opn, i - 5)};
      else if (i == 5 + nb) e = {2'b10, 8'h10};
      else e = {2'b10, 8'h70};
      if (lg[i] != e) bad++;
    end
    chk(bad == 0, "R2 R3 R5 bus byte sequence mismatches", bad, 0);
    chk(reads == (exp_to ? 0 : polls + 1), "R8 status reads", reads, exp_to ? 0 : polls + 1);
    for (int k = 0; k < 2000 && !nand_rb; k++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(lg_n == lg_done, "R1 no bus activity after done", lg_n, lg_done);
    chk(req_ready, "R1 req_ready back in idle", req_ready, 1);
  endtask

  initial begin
    int seed = $urandom(32'd12345);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1 reset req_ready", req_ready, 1);
    chk(nand_we_n && nand_re_n, "R1 reset strobes high", {nand_we_n, nand_re_n}, 3);
    chk(!nand_cle && !nand_ale, "R1 reset latches low", {nand_cle, nand_ale}, 0);
    chk(!done, "R1 reset done", done, 0);
    chk(!wr_ready, "R1 reset wr_ready", wr_ready, 0);
    // directed corners
    run_op(1, 32'h1234_5678, 1,   20,  0, 8'h40, 0);
    run_op(2, 32'hA5C3_0F01, 528, 30,  1, 8'hC0, 0);
    run_op(3, 32'h0000_00FF, 530, 25,  0, 8'h40, 0);
    run_op(4, 32'hDEAD_BEEF, 10,  15,  0, 8'h41, 1);
    run_op(5, 32'h0102_0304, 3,   600, 0, 8'h40, 0);
    run_op(6, 32'h7F00_8001, 2,   40,  3, 8'hFE, 1);
    // constrained random
    for (int r = 0; r < 6; r++)
      run_op(10 + r, $urandom, 1 + int'($urandom % 48), 3 + int'($urandom % 150),
             int'($urandom % 3), 8'($urandom) | 8'h40, bit'($urandom % 2));
    chk(viol_we == 0, "R4 we_n low width", viol_we, 0);
    chk(viol_re == 0, "R4 re_n low width", viol_re, 0);
    chk(viol_rb == 0, "R7 write cycle while busy", viol_rb, 0);
    chk(viol_quiet == 0, "R10 result flags outside done", viol_quiet, 0);
    if (seed == 0) $display("seed note");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule